// File: doc/BRIEF.md
# Masked Vector Leaky ReLU Unit

The unit applies a leaky rectifier to every lane of a floating-point vector in one registered stage. A lane whose element is non-negative keeps its value. A lane whose element is negative is replaced by the product of that element and a single slope scalar. The same slope is shared by all lanes. A per-lane predicate bit chooses which lanes take part in the operation. A lane with a clear predicate bit returns the matching element of the prior destination vector unchanged, so the result merges into the old register contents.

Each lane is a 32-bit field. A run-time format select picks the element type. In single-precision mode the whole field holds the element. In half-precision mode only bits [15:0] of each field, and of the slope, are used. The negative path uses a simplified IEEE multiplier in each lane with these rules:
- rounding is round-to-nearest-even;
- subnormal inputs and outputs are flushed to signed zero;
- overflow saturates to infinity;
- any invalid result becomes one canonical quiet NaN.

A new operation can be accepted on every cycle.

Top module: `lrelu_vec`

## Requirements
- R1: On an active lane, a source element that is not NaN and is either positive-signed or a zero of either sign (including +infinity) is copied to the output unchanged.
- R2: On an active lane, a negative non-NaN source element produces slope times source, rounded to nearest-even in the selected format.
- R3: One slope value drives the negative path of every active lane in the same operation.
- R4: A lane whose mask bit is 0 outputs its prior destination field, all 32 bits, unchanged, whatever the source and slope are.
- R5: fmt_i=0 selects single precision on all 32 bits of each lane. fmt_i=1 selects half precision on bits [15:0] of each lane and of the slope. In that mode an active lane drives bits [31:16] to zero and ignores the source's upper bits.
- R6: A NaN source, a NaN slope on the negative path, or an infinity multiplied by zero gives the canonical quiet NaN: 0x7FC00000 in single precision and 0x7E00 in half precision.
- R7: Subnormal operands of the multiply count as zero, and a product whose rounded exponent falls below the normal range becomes zero. In both cases the sign is the XOR of the operand signs.
- R8: A product whose rounded exponent exceeds the finite range, or an infinite operand times a non-zero finite operand, gives infinity with the XOR of the operand signs.
- R9: valid_o equals valid_i delayed by exactly one clock, and results appear in that same cycle.
- R10: dst_o keeps its value in any cycle that follows a cycle with valid_i low.
- R11: While rst_ni is low, valid_o and dst_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| fmt_i | input | 1 | Element format: 0 single, 1 half |
| mask_i | input | LANES | Per-lane predicate, 1 = active |
| slope_i | input | 32 | Broadcast negative-path slope |
| src_i | input | LANES*32 | Source vector, lane l at bits [32l+31:32l] |
| prev_i | input | LANES*32 | Prior destination vector for merging |
| valid_o | output | 1 | Result strobe |
| dst_o | output | LANES*32 | Result vector |

## Verification
A fault in the sign and NaN classification, the rounding increment or the exponent bounds shows up in the affected lane of dst_o. It is visible in the cycle after the operation, because the one-stage output register holds no other state. A wrong merge select or a wrong format steer corrupts whole 32-bit fields in that same next cycle. A faulty capture enable breaks the hold of dst_o during idle cycles. The bench compares every lane against its reference model on every clock, so any of these faults is reported within one cycle of the stimulus that exposes it.

// File: rtl/lrelu_pkg.sv
package lrelu_pkg;
  localparam int LANE_W = 32;
  localparam int F32_EW = 8;
  localparam int F32_MW = 23;
  localparam int F16_EW = 5;
  localparam int F16_MW = 10;

  typedef enum logic {
    FMT_F32 = 1'b0,
    FMT_F16 = 1'b1
  } fmt_e;
endpackage

// File: rtl/lrelu_fmul.sv
module lrelu_fmul #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] a_i,
  input  logic [EW+MW:0] b_i,
  output logic [EW+MW:0] p_o
);
  localparam int W    = EW + MW + 1;
  localparam int PW   = 2 * MW + 2;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EMAX = (1 << EW) - 1;

  logic          s;
  logic [EW-1:0] ea, eb;
  logic [MW-1:0] ma, mb;
  logic          a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
  logic [PW-1:0] prod, prod_n;
  logic          rnd_g, rnd_s, rnd_inc;
  logic [MW:0]   mant_r;
  int            e;

  always_comb begin
    s  = a_i[W-1] ^ b_i[W-1];
    ea = a_i[W-2:MW];
    eb = b_i[W-2:MW];
    ma = a_i[MW-1:0];
    mb = b_i[MW-1:0];
    a_nan  = (&ea) && (|ma);
    b_nan  = (&eb) && (|mb);
    a_inf  = (&ea) && !(|ma);
    b_inf  = (&eb) && !(|mb);
    a_zero = !(|ea);                 // subnormals flushed
    b_zero = !(|eb);

    prod    = PW'({1'b1, ma}) * PW'({1'b1, mb});
    prod_n  = prod[PW-1] ? prod : (prod << 1);
    rnd_g   = prod_n[MW];
    rnd_s   = |prod_n[MW-1:0];
    rnd_inc = rnd_g & (rnd_s | prod_n[MW+1]);
    mant_r  = {1'b0, prod_n[PW-2:MW+1]} + {{MW{1'b0}}, rnd_inc};
    e = int'(ea) + int'(eb) - BIAS + int'(prod[PW-1]) + int'(mant_r[MW]);

    if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero))
      p_o = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
    else if (a_inf || b_inf)
      p_o = {s, {EW{1'b1}}, {MW{1'b0}}};
    else if (a_zero || b_zero)
      p_o = {s, {(W-1){1'b0}}};
    else if (e >= EMAX)
      p_o = {s, {EW{1'b1}}, {MW{1'b0}}};
    else if (e <= 0)
      p_o = {s, {(W-1){1'b0}}};
    else
      p_o = {s, EW'(e), mant_r[MW-1:0]};
  end
endmodule

// File: rtl/lrelu_lane.sv
module lrelu_lane
  import lrelu_pkg::*;
(
  input  logic              fmt_i,
  input  logic              act_i,
  input  logic [LANE_W-1:0] src_i,
  input  logic [LANE_W-1:0] slope_i,
  input  logic [LANE_W-1:0] prev_i,
  output logic [LANE_W-1:0] res_o
);
  logic [31:0] m32;
  logic [15:0] m16;
  logic        nan32, nan16, pass32, pass16;

  lrelu_fmul #(.EW(F32_EW), .MW(F32_MW)) u_mul32 (
    .a_i(src_i), .b_i(slope_i), .p_o(m32)
  );

  lrelu_fmul #(.EW(F16_EW), .MW(F16_MW)) u_mul16 (
    .a_i(src_i[15:0]), .b_i(slope_i[15:0]), .p_o(m16)
  );

  always_comb begin
    nan32  = (&src_i[30:23]) && (|src_i[22:0]);
    nan16  = (&src_i[14:10]) && (|src_i[9:0]);
    // IEEE >= 0: -0 passes, NaN of either sign fails
    pass32 = !nan32 && (!src_i[31] || !(|src_i[30:0]));
    pass16 = !nan16 && (!src_i[15] || !(|src_i[14:0]));

    if (!act_i)
      res_o = prev_i;
    else if (fmt_i == FMT_F16)
      res_o = {16'h0000, pass16 ? src_i[15:0] : m16};
    else
      res_o = pass32 ? src_i : m32;
  end
endmodule

// File: rtl/lrelu_vec.sv
module lrelu_vec
  import lrelu_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    fmt_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANE_W-1:0]       slope_i,
  input  logic [LANES*LANE_W-1:0] src_i,
  input  logic [LANES*LANE_W-1:0] prev_i,
  output logic                    valid_o,
  output logic [LANES*LANE_W-1:0] dst_o
);
  localparam int VEC_W = LANES * LANE_W;

  logic [VEC_W-1:0] res_w;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lrelu_lane u_lane (
      .fmt_i  (fmt_i),
      .act_i  (mask_i[l]),
      .src_i  (src_i[l*LANE_W +: LANE_W]),
      .slope_i(slope_i),
      .prev_i (prev_i[l*LANE_W +: LANE_W]),
      .res_o  (res_w[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dst_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) dst_o <= res_w;
    end
  end
endmodule

// File: rtl/lrelu_vec_chk.sv
module lrelu_vec_chk
  import lrelu_pkg::*;
#(
  parameter int LANES = 64
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    fmt_i,
  input logic [LANES-1:0]        mask_i,
  input logic [LANE_W-1:0]       slope_i,
  input logic [LANES*LANE_W-1:0] src_i,
  input logic [LANES*LANE_W-1:0] prev_i,
  input logic                    valid_o,
  input logic [LANES*LANE_W-1:0] dst_o
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o); // R9
  AST_VALID_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> $stable(dst_o)); // R10

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    localparam int B = l * LANE_W;
    AST_MERGE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && !mask_i[l] |=> dst_o[B +: LANE_W] == $past(prev_i[B +: LANE_W])); // R4
    AST_HALF_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && mask_i[l] && fmt_i == FMT_F16 |=> dst_o[B+16 +: 16] == 16'h0000); // R5
    AST_POS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && mask_i[l] && fmt_i == FMT_F32 && !src_i[B+31] && src_i[B+23 +: 8] != 8'hFF
      |=> dst_o[B +: LANE_W] == $past(src_i[B +: LANE_W])); // R1
    AST_NAN_CANON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && mask_i[l] && fmt_i == FMT_F32 && (&src_i[B+23 +: 8]) && (|src_i[B +: 23])
      |=> dst_o[B +: LANE_W] == 32'h7FC0_0000); // R6
    AST_SLOPE_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && mask_i[l] && fmt_i == FMT_F32 && src_i[B+31] && src_i[B+23 +: 8] != 8'hFF
      && src_i[B+23 +: 8] != 8'h00 && slope_i[30:23] == 8'h00
      |=> dst_o[B +: LANE_W] == {~$past(slope_i[31]), 31'h0}); // R7
  end
endmodule

bind lrelu_vec lrelu_vec_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/lrelu_vec_test.sv
module lrelu_vec_test;
  localparam int LANES = 4;
  localparam int VW = LANES * 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          fmt_i = 1'b0;
  logic [LANES-1:0] mask_i = '0;
  logic [31:0]   slope_i = '0;
  logic [VW-1:0] src_i = '0;
  logic [VW-1:0] prev_i = '0;
  logic          valid_o;
  logic [VW-1:0] dst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] exp_lane [LANES];
  string       exp_req  [LANES];
  logic        exp_valid = 1'b0;

  always #5 clk_i = ~clk_i;

  lrelu_vec #(.LANES(LANES)) uut (.*);

  function automatic real f2r(logic [31:0] b, bit h);
    int mw = h ? 10 : 23;
    int bias = h ? 15 : 127;
    int e = h ? int'(b[14:10]) : int'(b[30:23]);
    int m = h ? int'(b[9:0]) : int'(b[22:0]);
    if (e == 0) return 0.0;
    return (1.0 + real'(m) / (2.0 ** mw)) * (2.0 ** (e - bias));
  endfunction

  function automatic logic [31:0] r2f(real mag, bit sgn, bit h);
    int mw = h ? 10 : 23;
    int ew = h ? 5 : 8;
    int bias = h ? 15 : 127;
    int emax = h ? 31 : 255;
    int e = 0;
    int ip, be;
    real frac, rem;
    logic [31:0] r;
    if (mag == 0.0) return 32'(sgn) << (ew + mw);
    while (mag >= 2.0) begin mag = mag / 2.0; e++; end
    while (mag < 1.0) begin mag = mag * 2.0; e--; end
    frac = (mag - 1.0) * (2.0 ** mw);
    ip = $rtoi(frac);
    rem = frac - real'(ip);
    if (rem > 0.5 || (rem == 0.5 && ip[0])) ip++;
    if (ip == (1 << mw)) begin ip = 0; e++; end
    be = e + bias;
    if (be >= emax) begin be = emax; ip = 0; end
    else if (be <= 0) begin be = 0; ip = 0; end
    r = (32'(sgn) << (ew + mw)) | (32'(be) << mw) | 32'(ip);
    return r;
  endfunction

  function automatic logic [31:0] ref_lane(logic [31:0] s, logic [31:0] k, logic [31:0] p,
                                           bit act, bit h, output string req);
    int mw = h ? 10 : 23;
    int emax = h ? 31 : 255;
    logic [31:0] qn = h ? 32'h0000_7E00 : 32'h7FC0_0000;
    logic [31:0] r;
    bit ss = h ? s[15] : s[31];
    bit ks = h ? k[15] : k[31];
    int se = h ? int'(s[14:10]) : int'(s[30:23]);
    int sm = h ? int'(s[9:0]) : int'(s[22:0]);
    int ke = h ? int'(k[14:10]) : int'(k[30:23]);
    int km = h ? int'(k[9:0]) : int'(k[22:0]);
    string hs = h ? ",R5" : "";
    if (!act) begin req = "R4"; return p; end
    if (se == emax && sm != 0) begin req = {"R6", hs}; return qn; end
    if (!ss || (se == 0 && sm == 0)) begin
      req = {"R1", hs};
      return h ? {16'h0, s[15:0]} : s;
    end
    if (ke == emax && km != 0) begin req = {"R6", hs}; return qn; end
    if ((se == emax && ke == 0) || (ke == emax && se == 0)) begin req = {"R6", hs}; return qn; end
    if (se == emax || ke == emax) begin
      req = {"R8", hs};
      return (32'(!ks) << (h ? 15 : 31)) | (32'(emax) << mw);
    end
    if (se == 0 || ke == 0) begin
      req = {"R7", hs};
      return 32'(!ks) << (h ? 15 : 31);
    end
    r = r2f(f2r(s, h) * f2r(k, h), !ks, h);
    if ((r >> mw) % (1 << (h ? 5 : 8)) == emax) req = {"R8", hs};
    else if ((r >> mw) % (1 << (h ? 5 : 8)) == 0) req = {"R7", hs};
    else req = {"R2,R3", hs};
    return r;
  endfunction

  function automatic logic [31:0] rand_fp(bit h);
    int cat = $urandom_range(0, 11);
    int emax = h ? 31 : 255;
    int bias = h ? 15 : 127;
    int mw = h ? 10 : 23;
    int e, m;
    bit sg = 1'($urandom_range(0, 1));
    m = int'($urandom() & ((1 << mw) - 1));
    case (cat)
      0: begin e = 0; m = 0; end
      1: begin e = emax; m = m | 1; end
      2: begin e = emax; m = 0; end
      3: begin e = 0; m = m | 1; end
      4: e = emax - 1 - $urandom_range(0, 1);
      5: e = 1 + $urandom_range(0, 1);
      default: e = bias - 4 + $urandom_range(0, 8);
    endcase
    if (h) return {16'($urandom()), 16'((int'(sg) << 15) | (e << 10) | m)};
    return (32'(sg) << 31) | (32'(e) << 23) | 32'(m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
    if (!rst_ni) begin
      exp_valid = 1'b0;
      for (int l = 0; l < LANES; l++) begin exp_lane[l] = '0; exp_req[l] = "R11"; end
    end else begin
      exp_valid = valid_i;
      for (int l = 0; l < LANES; l++) begin
        if (valid_i) begin
          string rq;
          exp_lane[l] = ref_lane(src_i[l*32 +: 32], slope_i, prev_i[l*32 +: 32],
                                 mask_i[l], fmt_i, rq);
          exp_req[l] = rq;
        end else exp_req[l] = "R10";
      end
    end
    @(negedge clk_i);
    check(rst_ni ? "R9" : "R11", 32'(valid_o), 32'(exp_valid));
    for (int l = 0; l < LANES; l++) check(exp_req[l], dst_o[l*32 +: 32], exp_lane[l]);
  endtask

  task automatic drive(bit v, bit h, logic [LANES-1:0] m, logic [31:0] k,
                       logic [31:0] s0, logic [31:0] s1, logic [31:0] s2, logic [31:0] s3);
    valid_i = v; fmt_i = h; mask_i = m; slope_i = k;
    src_i = {s3, s2, s1, s0};
    prev_i = {$urandom(), $urandom(), $urandom(), $urandom()};
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R11: reset holds outputs at zero despite activity
    drive(1, 0, 4'hF, 32'h3F00_0000, 32'hC000_0000, 32'h4040_0000, 32'hBF80_0000, 32'h1234_5678);
    drive(1, 1, 4'hF, 32'h0000_3400, 32'h0000_C000, 32'h0, 32'h0, 32'h0);
    rst_ni = 1'b1;
    // R1, R2, R3: f32 basic, shared slope 0.5
    drive(1, 0, 4'hF, 32'h3F00_0000, 32'hC000_0000, 32'h4040_0000, 32'hBF80_0000, 32'h8000_0000);
    // R2 rounding tie cases: slope 1.5 on odd mantissas
    drive(1, 0, 4'hF, 32'h3FC0_0000, 32'hBF80_0001, 32'hBF80_0003, 32'hBFFF_FFFF, 32'h7F80_0000);
    // R4 merge: inactive lanes keep prev
    drive(1, 0, 4'b0101, 32'h3F00_0000, 32'hC000_0000, 32'hC000_0000, 32'hC000_0000, 32'hC000_0000);
    // R5 half: -2.0*0.25, upper garbage ignored
    drive(1, 1, 4'hF, 32'hABCD_3400, 32'hFFFF_C000, 32'h1111_4000, 32'h0000_8000, 32'h5555_FC00);
    // R6 NaN cases
    drive(1, 0, 4'hF, 32'h0000_0000, 32'h7FC1_2345, 32'hFF80_0000, 32'hFFFF_FFFF, 32'hC000_0000);
    drive(1, 0, 4'hF, 32'h7F80_0001, 32'hC000_0000, 32'h3F80_0000, 32'h8000_0001, 32'h7F80_0001);
    // R7 flush and underflow
    drive(1, 0, 4'hF, 32'h0080_0000, 32'h8000_0001, 32'hBF00_0000, 32'h8080_0000, 32'hC000_0000);
    // R8 overflow
    drive(1, 0, 4'hF, 32'h7F00_0000, 32'hFF00_0000, 32'hC000_0000, 32'hFF80_0000, 32'h4000_0000);
    // R10 idle hold
    drive(0, 0, 4'hF, 32'h3F00_0000, 32'hC000_0000, 32'hC000_0000, 32'hC000_0000, 32'hC000_0000);
    drive(0, 1, 4'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    for (int i = 0; i < 4000; i++) begin
      bit h = 1'($urandom_range(0, 1));
      drive(1'($urandom_range(0, 4) != 0), h, 4'($urandom()), rand_fp(h),
            rand_fp(h), rand_fp(h), rand_fp(h), rand_fp(h));
    end
    finish_run();
  end
endmodule